// File: doc/BRIEF.md
# Masked Cache Area Purge Engine

This block keeps the tag arrays of two small direct-mapped caches, one for instructions and one for data, and adds a hardware purge walker to the data side. Software loads an address mask into the purge-mask register, then writes a base address with the start bit set into the purge-control register. The walker then scans every data-cache entry, one per clock. For each entry it rebuilds the line address from the stored tag and the entry index. It clears the valid bit when the masked line address equals the masked base. A busy bit in the purge-control register reads 1 for the whole scan, so software can poll it and know when the range is gone. One command can clear an aligned power-of-two region of any size, so software does not have to drop each tag by hand.

The cache-control register holds a separate enable bit for each cache and a separate whole-cache invalidate bit for each cache. An invalidate bit is a one-cycle pulse. On the clock after the write it clears every valid bit of that cache, and it always reads back as 0. A fill port writes a tag and sets its valid bit, and a lookup port reports hits. Together they let a test preload lines and see which ones survive.

The walker is a two-state machine. `WK_IDLE` goes to `WK_SCAN` on an accepted start command (transition *launch*). `WK_SCAN` stays in `WK_SCAN` while the scan index is below the last entry (transition *advance*). `WK_SCAN` goes back to `WK_IDLE` after the last entry has been checked (transition *finish*).

Top module: `cache_purge_engine`

## Requirements
- R1: After reset, all three registers read 0, no entry of either cache is valid, and `lk_hit` is 0.
- R2: Register 0 (cache control) stores bit 0 as the instruction-cache enable and bit 1 as the data-cache enable. It reads back with those two bits in place and every other bit 0, including the invalidate bits 4 and 5.
- R3: `lk_hit` is 1 only when the selected cache is enabled, the entry at index `lk_line[IDX_W-1:0]` is valid, and its stored tag equals `lk_line[LINE_W-1:IDX_W]`. A fill sets that entry's tag and valid bit on the next clock edge. `fill_sel`/`lk_sel` = 0 selects the instruction cache and 1 selects the data cache.
- R4: Writing register 0 with bit 4 (or bit 5) set clears every valid bit of the instruction (or data) cache on the following clock edge. The other cache is left untouched, and the bit does not stay set.
- R5: A write to register 2 (purge control) with bit 0 set while idle starts a scan. Bit 1 of register 2 reads 1 in each of the 16 cycles that follow the write, and 0 from the 17th cycle on.
- R6: During a scan, a valid data-cache line whose line address `{tag, index}` satisfies `(line ^ base) & mask[ADDR_W-1:OFFS_W] == 0` is cleared. Every other line survives, and instruction-cache lines are never touched by a scan.
- R7: A start command written while bit 1 of register 2 is 1 is ignored. The stored base does not change and the scan ends on its original schedule.
- R8: A write to register 2 with bit 0 clear starts nothing and leaves the stored base unchanged.
- R9: Register 1 (purge mask) reads back the last value written. Register 2 reads the stored base in bits `[ADDR_W-1:OFFS_W]`, busy in bit 1, and 0 elsewhere.
- R10: When a whole-cache invalidate takes effect on the same edge as a fill to that cache, the invalidate wins and the filled line is not valid afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 cache control, 1 purge mask, 2 purge control |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Read data of the register selected by `reg_addr` |
| fill_en | input | 1 | Write a tag and set valid |
| fill_sel | input | 1 | Fill target: 0 instruction, 1 data |
| fill_line | input | ADDR_W-OFFS_W | Line address to fill |
| lk_sel | input | 1 | Lookup target: 0 instruction, 1 data |
| lk_line | input | ADDR_W-OFFS_W | Line address to look up |
| lk_hit | output | 1 | Lookup hit |

## Verification
The bench preloads lines with two different tags. It then purges with a tag-only mask, with a mask that also covers the top index bit, and with an all-zero mask. A comparator that ignored the mask, or dropped the index from the rebuilt address, would clear the wrong half of the cache. The bench also reissues a start command in the middle of a scan and samples busy on the exact last cycle and on the cycle after it. A design that accepted a late command would show a changed base or a longer scan, and an off-by-one scan counter would show busy one cycle early or late. Finally, the bench fills a line on the same edge that a whole-cache invalidate lands, and switches a cache's enable off, to catch a wrong priority or an ungated hit.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

    typedef enum logic [0:0] {
        WK_IDLE = 1'b0,
        WK_SCAN = 1'b1
    } walk_state_e;

    localparam logic [1:0] RA_CACHE_CTL  = 2'd0;
    localparam logic [1:0] RA_PURGE_MASK = 2'd1;
    localparam logic [1:0] RA_PURGE_CTL  = 2'd2;

    localparam int unsigned NUM_CACHES = 2;
    localparam int unsigned SEL_ICACHE = 0;
    localparam int unsigned SEL_DCACHE = 1;

    localparam int unsigned CC_IEN  = 0;
    localparam int unsigned CC_DEN  = 1;
    localparam int unsigned CC_IINV = 4;
    localparam int unsigned CC_DINV = 5;

    localparam int unsigned PC_GO   = 0;
    localparam int unsigned PC_BUSY = 1;

endpackage

// File: rtl/cpe_regs.sv
module cpe_regs
    import cpe_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 4,
    localparam int unsigned LINE_W = ADDR_W - OFFS_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [1:0]            reg_addr,
    input  logic [ADDR_W-1:0]     reg_wdata,
    input  logic                  busy,
    input  logic [LINE_W-1:0]     base_hi,
    output logic [ADDR_W-1:0]     reg_rdata,
    output logic [NUM_CACHES-1:0] cache_en,
    output logic [NUM_CACHES-1:0] inv_pulse,
    output logic [LINE_W-1:0]     mask_hi,
    output logic                  go
);

    logic [ADDR_W-1:0] mask_q;
    logic              wr_ctl;
    logic              wr_mask;

    assign wr_ctl  = reg_we && (reg_addr == RA_CACHE_CTL);
    assign wr_mask = reg_we && (reg_addr == RA_PURGE_MASK);
    assign go      = reg_we && (reg_addr == RA_PURGE_CTL) && reg_wdata[PC_GO] && !busy;
    assign mask_hi = mask_q[ADDR_W-1:OFFS_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cache_en  <= '0;
            inv_pulse <= '0;
            mask_q    <= '0;
        end else begin
            inv_pulse <= '0;
            if (wr_ctl) begin
                cache_en[SEL_ICACHE]  <= reg_wdata[CC_IEN];
                cache_en[SEL_DCACHE]  <= reg_wdata[CC_DEN];
                inv_pulse[SEL_ICACHE] <= reg_wdata[CC_IINV];
                inv_pulse[SEL_DCACHE] <= reg_wdata[CC_DINV];
            end
            if (wr_mask) begin
                mask_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CACHE_CTL: begin
                reg_rdata[CC_IEN] = cache_en[SEL_ICACHE];
                reg_rdata[CC_DEN] = cache_en[SEL_DCACHE];
            end
            RA_PURGE_MASK: reg_rdata = mask_q;
            RA_PURGE_CTL: begin
                reg_rdata[ADDR_W-1:OFFS_W] = base_hi;
                reg_rdata[PC_BUSY]         = busy;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cpe_walker.sv
module cpe_walker
    import cpe_pkg::*;
#(
    parameter int unsigned LINE_W = 28,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned TAG_W = LINE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LINE_W-1:0] go_base,
    input  logic [LINE_W-1:0] mask_hi,
    input  logic              ent_valid,
    input  logic [TAG_W-1:0]  ent_tag,
    output logic              busy,
    output logic [IDX_W-1:0]  scan_idx,
    output logic              clr_en,
    output logic [LINE_W-1:0] base_hi
);

    walk_state_e       state_q;
    walk_state_e       state_nx;
    logic [IDX_W-1:0]  idx_nx;
    logic [LINE_W-1:0] line_addr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= WK_IDLE;
            scan_idx <= '0;
            base_hi  <= '0;
        end else begin
            state_q  <= state_nx;
            scan_idx <= idx_nx;
            if (go) begin
                base_hi <= go_base;
            end
        end
    end

    // next state: launch, advance, finish
    always_comb begin
        state_nx = state_q;
        idx_nx   = scan_idx;
        unique case (state_q)
            WK_IDLE: begin
                if (go) begin
                    state_nx = WK_SCAN;
                    idx_nx   = '0;
                end
            end
            WK_SCAN: begin
                idx_nx = scan_idx + 1'b1;
                if (scan_idx == '1) begin
                    state_nx = WK_IDLE;
                end
            end
            default: state_nx = WK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q == WK_SCAN);
        line_addr = {ent_tag, scan_idx};
        clr_en    = busy && ent_valid && (((line_addr ^ base_hi) & mask_hi) == '0);
    end

endmodule

// File: rtl/cpe_tag_store.sv
module cpe_tag_store #(
    parameter int unsigned IDX_W = 4,
    parameter int unsigned TAG_W = 24,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            inv_all,
    input  logic                            fill_en,
    input  logic [IDX_W-1:0]                fill_idx,
    input  logic [TAG_W-1:0]                fill_tag,
    input  logic                            clr_en,
    input  logic [IDX_W-1:0]                clr_idx,
    output logic [ENTRIES-1:0]              valid_o,
    output logic [ENTRIES-1:0][TAG_W-1:0]   tags_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= '0;
        end else if (inv_all) begin
            valid_o <= '0;
        end else begin
            if (clr_en) begin
                valid_o[clr_idx] <= 1'b0;
            end
            if (fill_en) begin
                valid_o[fill_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags_o <= '0;
        end else if (fill_en) begin
            tags_o[fill_idx] <= fill_tag;
        end
    end

endmodule

// File: rtl/cache_purge_engine.sv
module cache_purge_engine
    import cpe_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 4,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned LINE_W  = ADDR_W - OFFS_W,
    localparam int unsigned TAG_W   = LINE_W - IDX_W,
    localparam int unsigned ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              fill_en,
    input  logic              fill_sel,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              lk_sel,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit
);

    logic [NUM_CACHES-1:0]                         cache_en;
    logic [NUM_CACHES-1:0]                         inv_pulse;
    logic [LINE_W-1:0]                             mask_hi;
    logic [LINE_W-1:0]                             base_hi;
    logic                                          go;
    logic                                          busy;
    logic [IDX_W-1:0]                              scan_idx;
    logic                                          clr_en;
    logic [NUM_CACHES-1:0][ENTRIES-1:0]            valid_vec;
    logic [NUM_CACHES-1:0][ENTRIES-1:0][TAG_W-1:0] tag_arr;

    cpe_regs #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .base_hi   (base_hi),
        .reg_rdata (reg_rdata),
        .cache_en  (cache_en),
        .inv_pulse (inv_pulse),
        .mask_hi   (mask_hi),
        .go        (go)
    );

    cpe_walker #(
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_base   (reg_wdata[ADDR_W-1:OFFS_W]),
        .mask_hi   (mask_hi),
        .ent_valid (valid_vec[SEL_DCACHE][scan_idx]),
        .ent_tag   (tag_arr[SEL_DCACHE][scan_idx]),
        .busy      (busy),
        .scan_idx  (scan_idx),
        .clr_en    (clr_en),
        .base_hi   (base_hi)
    );

    for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
        logic c_fill;
        logic c_clr;
        assign c_fill = fill_en && (fill_sel == 1'(c));
        if (c == SEL_DCACHE) begin : g_purged
            assign c_clr = clr_en;
        end else begin : g_unpurged
            assign c_clr = 1'b0;
        end

        cpe_tag_store #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) u_tags (
            .clk      (clk),
            .rst_n    (rst_n),
            .inv_all  (inv_pulse[c]),
            .fill_en  (c_fill),
            .fill_idx (fill_line[IDX_W-1:0]),
            .fill_tag (fill_line[LINE_W-1:IDX_W]),
            .clr_en   (c_clr),
            .clr_idx  (scan_idx),
            .valid_o  (valid_vec[c]),
            .tags_o   (tag_arr[c])
        );
    end

    always_comb begin
        lk_hit = cache_en[lk_sel]
              && valid_vec[lk_sel][lk_line[IDX_W-1:0]]
              && (tag_arr[lk_sel][lk_line[IDX_W-1:0]] == lk_line[LINE_W-1:IDX_W]);
    end

endmodule

// File: rtl/cpe_checker.sv
module cpe_checker
    import cpe_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFFS_W = 4,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned LINE_W  = ADDR_W - OFFS_W,
    localparam int unsigned ENTRIES = 1 << IDX_W,
    localparam int unsigned CNT_W   = IDX_W + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  cmd_wr,
    input logic [LINE_W-1:0]     base_hi,
    input logic [NUM_CACHES-1:0] inv_pulse,
    input logic [ENTRIES-1:0]    ivalid,
    input logic [ENTRIES-1:0]    dvalid,
    input logic [1:0]            reg_addr,
    input logic [ADDR_W-1:0]     reg_rdata
);

    logic [CNT_W-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end else begin
            busy_cnt <= '0;
        end
    end

    p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < CNT_W'(ENTRIES)));

    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CNT_W'(ENTRIES)));

    p_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy) |=> busy);

    p_late_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && busy) |=> $stable(base_hi));

    p_iinv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_pulse[SEL_ICACHE] |=> (ivalid == '0));

    p_dinv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_pulse[SEL_DCACHE] |=> (dvalid == '0));

    p_inv_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_CACHE_CTL) |-> (reg_rdata[CC_IINV] == 1'b0 && reg_rdata[CC_DINV] == 1'b0));

    p_idle_keeps_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !inv_pulse[SEL_DCACHE]) |=> (($past(dvalid) & ~dvalid) == '0));

    p_scan_spares_i_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_pulse[SEL_ICACHE] |=> (($past(ivalid) & ~ivalid) == '0));

endmodule

bind cache_purge_engine cpe_checker #(
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .cmd_wr    (reg_we && (reg_addr == 2'd2) && reg_wdata[0]),
    .base_hi   (base_hi),
    .inv_pulse (inv_pulse),
    .ivalid    (valid_vec[0]),
    .dvalid    (valid_vec[1]),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/cache_purge_engine_test.sv
`timescale 1ns/1ps
module cache_purge_engine_test;

    localparam int NE = 16;
    localparam int WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fill_en = 1'b0;
    logic        fill_sel = 1'b0;
    logic [27:0] fill_line = '0;
    logic        lk_sel = 1'b0;
    logic [27:0] lk_line = '0;
    logic        lk_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    bit          m_v [2][NE];
    logic [23:0] m_t [2][NE];
    bit   [1:0]  m_en;
    bit   [1:0]  m_pend;
    logic [31:0] m_mask;
    logic [27:0] m_base;
    bit          m_busy;
    int          m_idx;

    always #5 clk = ~clk;

    cache_purge_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_en(fill_en),
        .fill_sel(fill_sel), .fill_line(fill_line), .lk_sel(lk_sel),
        .lk_line(lk_line), .lk_hit(lk_hit)
    );

    task automatic note(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_v[s, i]) begin m_v[s][i] = 1'b0; m_t[s][i] = '0; end
            m_en = '0; m_pend = '0; m_mask = '0; m_base = '0; m_busy = 1'b0; m_idx = 0;
        end else begin
            bit was_busy;
            logic [27:0] ln;
            was_busy = m_busy;
            if (m_busy) begin
                ln = {m_t[1][m_idx], 4'(m_idx)};
                if (m_v[1][m_idx] && (((ln ^ m_base) & m_mask[31:4]) == 28'd0))
                    m_v[1][m_idx] = 1'b0;
                m_idx++;
                if (m_idx == NE) m_busy = 1'b0;
            end
            if (fill_en) begin
                m_v[fill_sel][fill_line[3:0]] = 1'b1;
                m_t[fill_sel][fill_line[3:0]] = fill_line[27:4];
            end
            for (int s = 0; s < 2; s++)
                if (m_pend[s]) for (int i = 0; i < NE; i++) m_v[s][i] = 1'b0;
            m_pend = '0;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: begin m_en = {reg_wdata[1], reg_wdata[0]}; m_pend = {reg_wdata[5], reg_wdata[4]}; end
                    2'd1: m_mask = reg_wdata;
                    2'd2: if (reg_wdata[0] && !was_busy) begin
                        m_base = reg_wdata[31:4]; m_busy = 1'b1; m_idx = 0;
                    end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] er;
            logic        eh;
            case (reg_addr)
                2'd0: er = {30'd0, m_en};
                2'd1: er = m_mask;
                2'd2: er = {m_base, 2'b00, m_busy, 1'b0};
                default: er = '0;
            endcase
            note(reg_addr == 2'd0 ? "R2" : (reg_addr == 2'd1 ? "R9" : "R5"), reg_rdata, er);
            eh = m_en[lk_sel] && m_v[lk_sel][lk_line[3:0]] && (m_t[lk_sel][lk_line[3:0]] == lk_line[27:4]);
            note("R3", {31'd0, lk_hit}, {31'd0, eh});
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic fill(input logic s, input logic [23:0] tag, input logic [3:0] idx);
        fill_en = 1'b1; fill_sel = s; fill_line = {tag, idx};
        cyc();
        fill_en = 1'b0;
    endtask

    task automatic hit_is(input string req, input logic s, input logic [23:0] tag,
                          input logic [3:0] idx, input logic exp);
        lk_sel = s; lk_line = {tag, idx};
        @(negedge clk);
        note(req, {31'd0, lk_hit}, {31'd0, exp});
        cyc();
    endtask

    task automatic reg_is(input string req, input logic [1:0] a, input logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        note(req, reg_rdata, exp);
        cyc();
    endtask

    task automatic wait_idle();
        reg_addr = 2'd2;
        for (int k = 0; k < 40; k++) cyc();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        cyc();
        // R1 reset state
        reg_is("R1", 2'd0, 32'h0);
        reg_is("R1", 2'd1, 32'h0);
        reg_is("R1", 2'd2, 32'h0);
        hit_is("R1", 1'b1, 24'h0, 4'd0, 1'b0);

        // R2 enables and invalidate bits read 0
        wr(2'd0, 32'h0000_0033);
        reg_is("R2", 2'd0, 32'h0000_0003);

        // preload
        for (int i = 0; i < NE; i++) fill(1'b1, (i < 8) ? 24'h001000 : 24'h002000, 4'(i));
        for (int i = 0; i < NE; i++) fill(1'b0, 24'h001000, 4'(i));
        hit_is("R3", 1'b1, 24'h002000, 4'd9, 1'b1);
        hit_is("R3", 1'b1, 24'h001000, 4'd9, 1'b0);

        // R9 mask readback, R5 exact busy window, R6 tag-only purge
        wr(2'd1, 32'hFFFF_FF00);
        reg_is("R9", 2'd1, 32'hFFFF_FF00);
        reg_addr = 2'd2;
        wr(2'd2, 32'h0010_0001);
        @(negedge clk);
        note("R5", reg_rdata, 32'h0010_0002);
        for (int k = 1; k < NE; k++) @(negedge clk);
        note("R5", {31'd0, reg_rdata[1]}, 32'd1);
        @(negedge clk);
        note("R5", {31'd0, reg_rdata[1]}, 32'd0);
        cyc();
        hit_is("R6", 1'b1, 24'h001000, 4'd3, 1'b0);
        hit_is("R6", 1'b1, 24'h002000, 4'd9, 1'b1);
        hit_is("R6", 1'b0, 24'h001000, 4'd3, 1'b1);

        // R7 late command ignored
        wr(2'd2, 32'h0020_0001);
        cyc(); cyc();
        wr(2'd2, 32'h0010_0001);
        reg_is("R7", 2'd2, 32'h0020_0002);
        wait_idle();
        reg_is("R7", 2'd2, 32'h0020_0000);
        hit_is("R6", 1'b1, 24'h002000, 4'd12, 1'b0);

        // R8 write without start bit
        wr(2'd2, 32'h0030_0000);
        cyc();
        reg_is("R8", 2'd2, 32'h0020_0000);

        // R6 mask including top index bit
        for (int i = 0; i < NE; i++) fill(1'b1, 24'h00AB00, 4'(i));
        wr(2'd1, 32'hFFFF_FF80);
        wr(2'd2, 32'h00AB_0081);
        wait_idle();
        hit_is("R6", 1'b1, 24'h00AB00, 4'd2, 1'b1);
        hit_is("R6", 1'b1, 24'h00AB00, 4'd12, 1'b0);

        // R6 all-zero mask clears everything valid
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1234_5671);
        wait_idle();
        hit_is("R6", 1'b1, 24'h00AB00, 4'd2, 1'b0);

        // R4 instruction-cache whole invalidate
        fill(1'b1, 24'h000005, 4'd1);
        wr(2'd0, 32'h0000_0013);
        cyc();
        hit_is("R4", 1'b0, 24'h001000, 4'd8, 1'b0);
        hit_is("R4", 1'b1, 24'h000005, 4'd1, 1'b1);
        reg_is("R4", 2'd0, 32'h0000_0003);

        // R10 invalidate beats fill on the same edge
        wr(2'd0, 32'h0000_0023);
        fill(1'b1, 24'h000007, 4'd6);
        hit_is("R10", 1'b1, 24'h000007, 4'd6, 1'b0);
        hit_is("R4", 1'b1, 24'h000005, 4'd1, 1'b0);
        fill(1'b1, 24'h000007, 4'd6);
        hit_is("R3", 1'b1, 24'h000007, 4'd6, 1'b1);

        // R3 enable gates hits
        wr(2'd0, 32'h0000_0001);
        hit_is("R3", 1'b1, 24'h000007, 4'd6, 1'b0);
        wr(2'd0, 32'h0000_0003);
        hit_is("R3", 1'b1, 24'h000007, 4'd6, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule